// File: doc/BRIEF.md
# Region Permission Checker for Pre-Translation Addresses

This block adds a fine-grained access check to loads and stores, applied to the virtual address before any translation. Software programs up to eight regions. Each region has a naturally aligned, power-of-two size and is split into 128 equal subregions. Every subregion has its own read-permission bit and its own write-permission bit. A typical use is to fence off a heap so that a collector can trap selected reads or writes without touching page tables.

Each region is described by one tag register and four 64-bit permission words: read-low, read-high, write-low and write-high. A global enable bit gates the whole check. Configuration goes through a simple register port. The write takes effect on the clock edge, and the read data is combinational. Requests arrive as a valid strobe, an address and a store flag. One cycle later the block reports three things: whether the access faults, which region decided the result, or that no region matched.

Top module: `vperm_chk`

## Requirements
- R1: After a synchronous active-low reset, all response outputs are 0. Every configuration register reads 0, and the enable bit is clear.
- R2: Tag registers keep only bits VAW-1:11 of the written value. On read, bits 10:0 and every bit from VAW up to 63 return 0.
- R3: Let S be the number of consecutive zeros counted upward from bit 11 of a tag. A region hits when request address bits VAW-1:12+S equal the same tag bits. Request address bits at or above VAW are ignored.
- R4: A tag whose bits VAW-1:11 hold only the top bit matches every address.
- R5: A tag with no 1 in bits VAW-1:11 is disabled and never hits.
- R6: When several regions hit, the lowest-numbered region decides the result, and its number appears on rsp_region.
- R7: When no region hits, the access is allowed: rsp_fault=0, rsp_nomatch=1 and rsp_region=0.
- R8: For a load, address bits 11+S:5+S form a 7-bit subregion index. Indexes 0 to 63 select that bit of the read-low word, and indexes 64 to 127 select bit (index-64) of the read-high word. A 0 in the selected bit sets rsp_fault.
- R9: For a store (req_store=1), the same index selects a bit from the write-low or write-high word. A 0 in the selected bit sets rsp_fault.
- R10: While the enable bit is clear, every request gives rsp_fault=0 and rsp_nomatch=1.
- R11: rsp_valid is req_valid delayed by one cycle. Without a request, rsp_fault, rsp_nomatch and rsp_region are 0.
- R12: A request in the same cycle as a configuration write is judged with the values held before that write.
- R13: Register map. csr_addr[5:3] selects the region and csr_addr[2:0] selects the register: 0 = tag, 1 = read-low, 2 = read-high, 3 = write-low, 4 = write-high. Address 7 is the control register, whose bit 0 is the enable and whose other bits read 0. Any other address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Configuration write strobe |
| csr_addr | input | 6 | Configuration register address |
| csr_wdata | input | 64 | Configuration write data |
| csr_rdata | output | 64 | Configuration read data (combinational) |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 64 | Request virtual address |
| req_store | input | 1 | 1 = store, 0 = load |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_fault | output | 1 | Access fault |
| rsp_nomatch | output | 1 | No region decided the access |
| rsp_region | output | 3 | Deciding region number |

## Verification
The bench drives loads and stores at subregion indexes 0, 1, 63, 64 and 127. These addresses separate the low words from the high words and separate read bits from write bits.

Addresses just inside and just outside a region with the smallest size (S=0) and a region with a larger size (S=3) show whether the tag compare starts at the right bit. Stacked regions show the priority: an all-space region, an overlapping higher-numbered region and a disabled tag. A request issued in the same cycle as a permission write shows that the old value is used.

Random traffic then mixes addresses, directions and permission rewrites against a behavioural model.

// File: rtl/vperm_pkg.sv
// Package vperm_pkg
// Shared constants and the register selector encoding for the region
// permission checker. Assumes a 64-bit data path for configuration.
package vperm_pkg;
    localparam int XLEN    = 64;
    localparam int CSR_AW  = 6;
    localparam int RSEL_W  = 3;
    localparam int SUB_W   = 7;

    typedef enum logic [2:0] {
        KIND_TAG  = 3'd0,
        KIND_RDLO = 3'd1,
        KIND_RDHI = 3'd2,
        KIND_WRLO = 3'd3,
        KIND_WRHI = 3'd4,
        KIND_CTRL = 3'd7
    } csr_kind_e;
endpackage

// File: rtl/vperm_region.sv
// Module vperm_region
// One protection region: stores the legalized tag and four permission
// words, decides whether a request address falls inside the region and
// which permission bit governs it. Assumes 12 <= VAW < 64.
module vperm_region
    import vperm_pkg::*;
#(
    parameter int VAW = 39
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  csr_kind_e         kind,
    input  logic [XLEN-1:0]   wr_data,
    output logic [XLEN-1:0]   rd_data,
    input  logic [VAW-1:0]    chk_addr,
    input  logic              chk_store,
    output logic              hit,
    output logic              allow
);
    localparam int TW = VAW - 11;
    localparam int SW = (TW > 1) ? $clog2(TW) : 1;

    logic [TW-1:0]   tag_q;
    logic [XLEN-1:0] rlo_q, rhi_q, wlo_q, whi_q;
    logic [SW-1:0]   size_s;
    logic [TW-1:0]   low_ones;
    logic [VAW-1:0]  shifted;
    logic [SUB_W-1:0] sub_idx;
    logic [XLEN-1:0] sel_lo, sel_hi;

    // Register storage with WARL tag legalization (only VAW-1:11 kept).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
            rlo_q <= '0;
            rhi_q <= '0;
            wlo_q <= '0;
            whi_q <= '0;
        end else if (wr_en) begin
            case (kind)
                KIND_TAG:  tag_q <= wr_data[VAW-1:11];
                KIND_RDLO: rlo_q <= wr_data;
                KIND_RDHI: rhi_q <= wr_data;
                KIND_WRLO: wlo_q <= wr_data;
                KIND_WRHI: whi_q <= wr_data;
                default:   ;
            endcase
        end
    end

    // Read-back multiplexer for this region's registers.
    always_comb begin
        case (kind)
            KIND_TAG:  rd_data = XLEN'({tag_q, 11'b0});
            KIND_RDLO: rd_data = rlo_q;
            KIND_RDHI: rd_data = rhi_q;
            KIND_WRLO: rd_data = wlo_q;
            KIND_WRHI: rd_data = whi_q;
            default:   rd_data = '0;
        endcase
    end

    // Region size: position of the lowest set tag bit.
    always_comb begin
        size_s = '0;
        for (int i = TW - 1; i >= 0; i--) begin
            if (tag_q[i]) size_s = SW'(i);
        end
    end

    // Hit test: compare only tag bits above the lowest set bit.
    assign low_ones = tag_q ^ (tag_q - TW'(1));
    assign hit      = (|tag_q) &&
                      (((chk_addr[VAW-1:11] ^ tag_q) & ~low_ones) == '0);

    // Subregion index and permission bit selection.
    assign shifted = chk_addr >> size_s;
    assign sub_idx = shifted[11:5];
    assign sel_lo  = chk_store ? wlo_q : rlo_q;
    assign sel_hi  = chk_store ? whi_q : rhi_q;
    assign allow   = sub_idx[6] ? sel_hi[sub_idx[5:0]] : sel_lo[sub_idx[5:0]];
endmodule

// File: rtl/vperm_prio.sv
// Module vperm_prio
// Fixed-priority pick among region hits: the lowest index wins and passes
// its permission result. Assumes N <= 2**IW.
module vperm_prio #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  hit,
    input  logic [N-1:0]  allow,
    output logic          any_hit,
    output logic [IW-1:0] win_idx,
    output logic          win_allow
);
    // Scan from the top so the lowest hitting index is applied last.
    always_comb begin
        any_hit   = 1'b0;
        win_idx   = '0;
        win_allow = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any_hit   = 1'b1;
                win_idx   = IW'(i);
                win_allow = allow[i];
            end
        end
    end
endmodule

// File: rtl/vperm_chk.sv
// Module vperm_chk (top)
// Region permission checker: configuration port, NUM_REG regions, priority
// selection and a registered response one cycle after each request.
// Assumes 1 <= NUM_REG <= 8 and 12 <= VAW < 64.
module vperm_chk
    import vperm_pkg::*;
#(
    parameter int NUM_REG = 8,
    parameter int VAW     = 39
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [5:0]        csr_addr,
    input  logic [63:0]       csr_wdata,
    output logic [63:0]       csr_rdata,
    input  logic              req_valid,
    input  logic [63:0]       req_addr,
    input  logic              req_store,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic              rsp_nomatch,
    output logic [2:0]        rsp_region
);
    logic                 en_q;
    csr_kind_e            csr_kind;
    logic [RSEL_W-1:0]    csr_rsel;
    logic [NUM_REG-1:0]   hit_v, allow_v;
    logic [XLEN-1:0]      rd_v [NUM_REG];
    logic                 any_hit, win_allow;
    logic [RSEL_W-1:0]    win_idx;

    assign csr_kind = csr_kind_e'(csr_addr[2:0]);
    assign csr_rsel = csr_addr[5:3];

    // Global enable bit in the control register.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else if (csr_we && csr_kind == KIND_CTRL && csr_rsel == '0)
            en_q <= csr_wdata[0];
    end

    // One region instance per implemented region.
    for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
        vperm_region #(.VAW(VAW)) u_rg (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (csr_we && csr_rsel == RSEL_W'(g)),
            .kind      (csr_kind),
            .wr_data   (csr_wdata),
            .rd_data   (rd_v[g]),
            .chk_addr  (req_addr[VAW-1:0]),
            .chk_store (req_store),
            .hit       (hit_v[g]),
            .allow     (allow_v[g])
        );
    end

    // Configuration read multiplexer.
    always_comb begin
        csr_rdata = '0;
        if (csr_kind == KIND_CTRL) begin
            if (csr_rsel == '0) csr_rdata = XLEN'(en_q);
        end else begin
            for (int i = 0; i < NUM_REG; i++) begin
                if (csr_rsel == RSEL_W'(i)) csr_rdata = rd_v[i];
            end
        end
    end

    vperm_prio #(.N(NUM_REG), .IW(RSEL_W)) u_prio (
        .hit       (hit_v),
        .allow     (allow_v),
        .any_hit   (any_hit),
        .win_idx   (win_idx),
        .win_allow (win_allow)
    );

    // Registered response stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_fault   <= 1'b0;
            rsp_nomatch <= 1'b0;
            rsp_region  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid && en_q && any_hit) begin
                rsp_fault   <= ~win_allow;
                rsp_nomatch <= 1'b0;
                rsp_region  <= win_idx;
            end else begin
                rsp_fault   <= 1'b0;
                rsp_nomatch <= req_valid;
                rsp_region  <= '0;
            end
        end
    end
endmodule

// File: rtl/vperm_chk_sva.sv
// Module vperm_chk_sva
// Property checker bound to vperm_chk. Observes ports and the enable state.
module vperm_chk_sva #(
    parameter int NUM_REG = 8,
    parameter int VAW     = 39
) (
    input logic        clk,
    input logic        rst_n,
    input logic [5:0]  csr_addr,
    input logic [63:0] csr_rdata,
    input logic        req_valid,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic        rsp_nomatch,
    input logic [2:0]  rsp_region,
    input logic        en_q
);
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_fault && !rsp_nomatch && rsp_region == 3'd0));
    a_r7_nomatch_allows: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_nomatch |-> (!rsp_fault && rsp_region == 3'd0));
    a_r10_disabled_allows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !en_q) |=> (rsp_valid && !rsp_fault && rsp_nomatch));
    a_r2_tag_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr[2:0] == 3'd0) |-> (csr_rdata[10:0] == 11'd0 && csr_rdata[63:VAW] == '0));
    a_r13_ctrl_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == 6'd7) |-> (csr_rdata[63:1] == 63'd0));
    a_r6_region_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_nomatch) |-> (32'(rsp_region) < NUM_REG));
endmodule

bind vperm_chk vperm_chk_sva #(.NUM_REG(NUM_REG), .VAW(VAW)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_addr    (csr_addr),
    .csr_rdata   (csr_rdata),
    .req_valid   (req_valid),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_nomatch (rsp_nomatch),
    .rsp_region  (rsp_region),
    .en_q        (en_q)
);

// File: tb/tb_vperm_chk.sv
// Bench for vperm_chk: behavioural model with per-cycle response compare.
module tb_vperm_chk;
    localparam int NREG = 8;
    localparam int VAW  = 39;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [5:0]  csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        req_store = 1'b0;
    logic        rsp_valid, rsp_fault, rsp_nomatch;
    logic [2:0]  rsp_region;

    int tests = 0;
    int fails = 0;

    logic [63:0] m_tag [NREG];
    logic [63:0] m_rl  [NREG];
    logic [63:0] m_rh  [NREG];
    logic [63:0] m_wl  [NREG];
    logic [63:0] m_wh  [NREG];
    bit          m_en;

    always #5 clk = ~clk;

    vperm_chk #(.NUM_REG(NREG), .VAW(VAW)) dut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_store(req_store), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_nomatch(rsp_nomatch), .rsp_region(rsp_region)
    );

    function automatic logic [63:0] legal_tag(input logic [63:0] d);
        logic [63:0] r = '0;
        for (int j = 11; j < VAW; j++) r[j] = d[j];
        return r;
    endfunction

    function automatic logic [63:0] model_read(input logic [5:0] a);
        int r = int'(a[5:3]);
        int k = int'(a[2:0]);
        if (k == 7) return (r == 0) ? {63'd0, m_en} : 64'd0;
        if (r >= NREG) return 64'd0;
        case (k)
            0: return m_tag[r];
            1: return m_rl[r];
            2: return m_rh[r];
            3: return m_wl[r];
            4: return m_wh[r];
            default: return 64'd0;
        endcase
    endfunction

    task automatic model_write(input logic [5:0] a, input logic [63:0] d);
        int r = int'(a[5:3]);
        int k = int'(a[2:0]);
        if (k == 7) begin
            if (r == 0) m_en = d[0];
        end else if (r < NREG) begin
            case (k)
                0: m_tag[r] = legal_tag(d);
                1: m_rl[r] = d;
                2: m_rh[r] = d;
                3: m_wl[r] = d;
                4: m_wh[r] = d;
                default: ;
            endcase
        end
    endtask

    task automatic predict(input bit rv, input logic [63:0] ra, input bit st,
                           output bit ev, output bit ef, output bit en,
                           output logic [2:0] er);
        bit found = 0;
        ev = rv; ef = 0; en = 0; er = 3'd0;
        if (!rv) return;
        if (!m_en) begin en = 1; return; end
        for (int r = 0; r < NREG; r++) begin
            int s = -1;
            bit ok = 1;
            if (found) continue;
            for (int j = 11; j < VAW; j++) begin
                if (m_tag[r][j]) begin s = j - 11; break; end
            end
            if (s < 0) continue;
            for (int j = 12 + s; j < VAW; j++) if (ra[j] != m_tag[r][j]) ok = 0;
            if (ok) begin
                int idx = int'((ra >> (5 + s)) & 64'd127);
                bit pb;
                if (st) pb = (idx < 64) ? m_wl[r][idx] : m_wh[r][idx - 64];
                else    pb = (idx < 64) ? m_rl[r][idx] : m_rh[r][idx - 64];
                found = 1;
                er = 3'(r);
                ef = !pb;
            end
        end
        if (!found) en = 1;
    endtask

    // One clock: drive at negedge, predict, advance, compare at next negedge.
    task automatic step(input bit we, input logic [5:0] a, input logic [63:0] d,
                        input bit rv, input logic [63:0] ra, input bit st,
                        input string tag);
        bit ev, ef, en;
        logic [2:0] er;
        csr_we = we; csr_addr = a; csr_wdata = d;
        req_valid = rv; req_addr = ra; req_store = st;
        predict(rv, ra, st, ev, ef, en, er);
        @(posedge clk);
        if (we) model_write(a, d);
        @(negedge clk);
        csr_we = 1'b0; req_valid = 1'b0;
        tests++;
        if ({rsp_valid, rsp_fault, rsp_nomatch, rsp_region} !== {ev, ef, en, er}) begin
            fails++;
            $display("FAIL %s: addr=%h st=%0d got v=%0d f=%0d nm=%0d rg=%0d exp v=%0d f=%0d nm=%0d rg=%0d",
                     tag, ra, st, rsp_valid, rsp_fault, rsp_nomatch, rsp_region,
                     ev, ef, en, er);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [63:0] d, input string tag);
        step(1'b1, a, d, 1'b0, 64'd0, 1'b0, tag);
    endtask

    task automatic rq(input logic [63:0] ra, input bit st, input string tag);
        step(1'b0, 6'd0, 64'd0, 1'b1, ra, st, tag);
    endtask

    task automatic rd_check(input logic [5:0] a, input string tag);
        logic [63:0] e;
        csr_addr = a;
        #1;
        e = model_read(a);
        tests++;
        if (csr_rdata !== e) begin
            fails++;
            $display("FAIL %s: csr %0d got %h exp %h", tag, a, csr_rdata, e);
        end
    endtask

    function automatic logic [5:0] ca(input int r, input int k);
        return {3'(r), 3'(k)};
    endfunction

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    localparam logic [63:0] B0 = 64'h0000_0000_1000_0000;
    localparam logic [63:0] B1 = 64'h0000_0000_2000_0000;
    localparam logic [63:0] B2 = 64'h0000_0000_4000_0000;

    initial begin
        for (int r = 0; r < NREG; r++) begin
            m_tag[r] = '0; m_rl[r] = '0; m_rh[r] = '0; m_wl[r] = '0; m_wh[r] = '0;
        end
        m_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of outputs and registers
        tests++;
        if ({rsp_valid, rsp_fault, rsp_nomatch, rsp_region} !== 6'd0) begin
            fails++;
            $display("FAIL R1: outputs got %b exp 0", {rsp_valid, rsp_fault, rsp_nomatch, rsp_region});
        end
        for (int k = 0; k < 5; k++) rd_check(ca(0, k), "R1");
        rd_check(6'd7, "R1");
        step(1'b0, 6'd0, 64'd0, 1'b0, 64'd0, 1'b0, "R11");

        // R2 / R13: legalization and control register
        wr(ca(0, 0), 64'hFFFF_FFFF_FFFF_FFFF, "R2");
        rd_check(ca(0, 0), "R2");
        wr(ca(0, 7), 64'hFFFF_FFFF_FFFF_FFFF, "R13");
        rd_check(6'd7, "R13");
        rd_check(ca(3, 7), "R13");
        rd_check(ca(2, 5), "R13");
        wr(ca(0, 7), 64'd0, "R13");

        // R10: all-space region with zero permissions, enable clear
        wr(ca(0, 0), 64'd1 << (VAW - 1), "R4");
        rq(64'h0000_0000_0012_3456, 1'b0, "R10");
        rq(64'h0000_0000_0012_3456, 1'b1, "R10");
        wr(ca(0, 7), 64'd1, "R10");
        rq(64'h0000_0000_0012_3456, 1'b0, "R4");

        // Region 0: S=3 at B0, region size 32 KiB, subregion stride 256 B
        wr(ca(0, 0), B0 | (64'd1 << 14), "R3");
        wr(ca(0, 1), 64'hAAAA_AAAA_AAAA_AAAA, "R8");
        wr(ca(0, 2), 64'h8000_0000_0000_0001, "R8");
        wr(ca(0, 3), 64'h5555_5555_5555_5555, "R9");
        wr(ca(0, 4), 64'h7FFF_FFFF_FFFF_FFFE, "R9");
        for (int i = 0; i < 5; i++) begin
            int idx;
            case (i) 0: idx = 0; 1: idx = 1; 2: idx = 63; 3: idx = 64; default: idx = 127; endcase
            rq(B0 + 64'(idx) * 64'd256, 1'b0, "R8");
            rq(B0 + 64'(idx) * 64'd256 + 64'd255, 1'b1, "R9");
        end
        rq(B0 + 64'h8000, 1'b0, "R3");
        rq(B0 - 64'd1, 1'b0, "R7");
        rq(64'hFFFF_FF80_1000_0100, 1'b0, "R3");

        // Region 1: S=0 at B1 (4 KiB)
        wr(ca(1, 0), B1 | (64'd1 << 11), "R3");
        wr(ca(1, 1), 64'd0, "R3");
        rq(B1 + 64'hFFF, 1'b0, "R3");
        rq(B1 + 64'h1000, 1'b0, "R3");
        rq(B1 + 64'h800, 1'b1, "R3");

        // R5: tag written with only low bits stays disabled
        wr(ca(2, 0), 64'h7FF, "R5");
        rd_check(ca(2, 0), "R5");
        rq(64'd0, 1'b0, "R5");
        rq(B2, 1'b1, "R5");

        // R6: region 3 overlaps region 0 with full permissions
        wr(ca(3, 0), B0 | (64'd1 << 14), "R6");
        wr(ca(3, 1), '1, "R6");
        wr(ca(3, 2), '1, "R6");
        rq(B0, 1'b0, "R6");
        rq(B0 + 64'd64 * 64'd256, 1'b0, "R6");

        // R4: all-space region 7 catches everything else
        wr(ca(7, 0), 64'd1 << (VAW - 1), "R4");
        wr(ca(7, 3), 64'h0, "R4");
        rq(B2 + 64'h1234, 1'b1, "R4");
        rq(B2 + 64'h1234, 1'b0, "R4");

        // R12: write read-low of region 0 in the same cycle as a load
        step(1'b1, ca(0, 1), 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, B0 + 64'd256, 1'b0, "R12");
        rq(B0 + 64'd256, 1'b0, "R12");

        // Random traffic against the model
        for (int n = 0; n < 600; n++) begin
            logic [63:0] a;
            int pick = int'($urandom_range(0, 3));
            case (pick)
                0: a = B0 + 64'($urandom_range(0, 32'h7FFF));
                1: a = B1 + 64'($urandom_range(0, 32'h1FFF));
                2: a = {$urandom, $urandom};
                default: a = B2 + 64'($urandom);
            endcase
            if ($urandom_range(0, 5) == 0)
                step(1'b1, ca(int'($urandom_range(0, 7)), int'($urandom_range(1, 4))),
                     {$urandom, $urandom}, 1'b1, a, 1'($urandom), "R8");
            else
                step(1'b0, 6'd0, 64'd0, 1'($urandom_range(0, 7) != 0), a, 1'($urandom), "R9");
            if (n % 50 == 0) rd_check(ca(int'($urandom_range(0, 7)), int'($urandom_range(0, 7))), "R13");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule